// File: doc/BRIEF.md
# Ping-pong receive buffer toggle controller

This block keeps the bookkeeping for two alternating receive buffers, A and B. A data source fills the buffer selected by a toggle bit. When a fill completes, the buffer's full flag is set and the toggle moves to the other buffer if that buffer is empty. A consumer drains the full buffers. Each flag is released either by a software write-1-to-clear strobe or, in auto-transfer mode, by the drain-complete strobe of that buffer.

When both buffers hold data, the toggle stays where it is and the active source is throttled. A USB endpoint source gets a hold-off indication, so that its protocol engine answers further OUT transactions with NYET or NAK. A disk-interface DMA source has its acknowledge withheld, so no word is accepted. A fill strobe that arrives while no buffer is free is dropped and sets a sticky overrun flag. The SRAM, the data movement and the protocol engines are outside this block.

Top module: `pingpong_toggle_ctrl`

## Requirements
- R1: After reset, fullA, fullB, toggle, overrun, bothFull, usbHoldOff and dmaAck are all 0.
- R2: On a fillDone strobe with at least one buffer empty, the full flag of the buffer selected by toggle is set: toggle=0 selects A and toggle=1 selects B.
- R3: Whenever exactly one buffer is full, toggle points at the empty one: it is 1 when only A is full and 0 when only B is full.
- R4: While both buffers are full, toggle keeps its value, and a fillDone strobe changes neither full flag.
- R5: A fillDone strobe while both buffers are full sets overrun, which then stays 1 until reset.
- R6: With autoXfer=0, swClrA or swClrB clears the matching full flag, and drainDoneA and drainDoneB have no effect.
- R7: With autoXfer=1, drainDoneA or drainDoneB clears the matching full flag, and swClrA and swClrB have no effect.
- R8: A fill into one buffer and a clear of the other buffer in the same cycle both take effect.
- R9: When a clear leaves both buffers empty, toggle becomes 1 if only B was cleared and 0 otherwise. When both buffers are empty and nothing was cleared, toggle holds.
- R10: usbHoldOff is 1 exactly when both buffers are full and srcSel=0 (the USB endpoint source).
- R11: dmaAck is 1 exactly when srcSel=1 (the disk DMA source), dmaReq=1 and the buffers are not both full.
- R12: bothFull equals fullA AND fullB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fillDone | input | 1 | Strobe: the fill of the buffer selected by toggle has completed |
| swClrA | input | 1 | Software write-1-to-clear strobe for the A full flag |
| swClrB | input | 1 | Software write-1-to-clear strobe for the B full flag |
| autoXfer | input | 1 | 1 = flags are cleared by drain completion, 0 = by software |
| drainDoneA | input | 1 | Strobe: draining of buffer A has completed |
| drainDoneB | input | 1 | Strobe: draining of buffer B has completed |
| srcSel | input | 1 | Active source: 0 = USB endpoint, 1 = disk DMA |
| dmaReq | input | 1 | DMA request from the disk source |
| usbHoldOff | output | 1 | Ask the USB engine to reply NYET/NAK to OUT transactions |
| dmaAck | output | 1 | DMA acknowledge to the disk source |
| fullA | output | 1 | Status: buffer A holds data |
| fullB | output | 1 | Status: buffer B holds data |
| toggle | output | 1 | Status: buffer for the next fill (0 = A, 1 = B) |
| bothFull | output | 1 | Status: both buffers hold data |
| overrun | output | 1 | Sticky status: a fill arrived with no buffer free |

## Verification
The bench goes after these corner cases:
- A third fill while both buffers are full. A design that got this wrong would overwrite a flag or move the toggle, and would leave overrun low.
- A clear that empties the last full buffer. If the toggle were not forced here, the next fill would land in the wrong buffer.
- A fill and a clear of the other buffer in the same cycle. A design that handled this wrong would lose one of the two events.
- A mode change between software and drain clears. A bench that missed this would not see a stale strobe of the other kind releasing a flag.
- Flow control with each source selected. The check confirms that only the selected source is throttled.

Random stimulus with a fixed seed follows the directed sequence and covers the remaining combinations.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int NUM_BUF = 2;
  localparam int SEL_W = $clog2(NUM_BUF);

  typedef struct packed {
    logic [NUM_BUF-1:0] setFull;
    logic [NUM_BUF-1:0] clrFull;
    logic               overrun;
  } ppStrobe_t;
endpackage

// File: rtl/pp_ctrl.sv
module pp_ctrl
  import pp_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               fillDone,
  input  logic [NUM_BUF-1:0] swClr,
  input  logic [NUM_BUF-1:0] drainDone,
  input  logic               autoXfer,
  input  logic [NUM_BUF-1:0] fullQ,
  input  logic [SEL_W-1:0]   toggleQ,
  output ppStrobe_t          strobe
);
  logic [NUM_BUF-1:0] setVec;
  logic [NUM_BUF-1:0] clrVec;
  logic               allFull;

  assign allFull = &fullQ;

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
    assign setVec[i] = fillDone & ~allFull & (toggleQ == SEL_W'(i));
    assign clrVec[i] = fullQ[i] & (autoXfer ? drainDone[i] : swClr[i]);
  end

  always_comb begin
    strobe.setFull = setVec;
    strobe.clrFull = clrVec;
    strobe.overrun = fillDone & allFull;
  end

  AST_AUTO_IGNORES_SW: assert property (@(posedge clk) disable iff (!rstN)
    (autoXfer && drainDone == '0) |-> strobe.clrFull == '0); // R7
  AST_NORMAL_IGNORES_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    (!autoXfer && swClr == '0) |-> strobe.clrFull == '0); // R6
  AST_SINGLE_SET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.setFull)); // R2
endmodule

// File: rtl/pp_regs.sv
module pp_regs
  import pp_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ppStrobe_t          strobe,
  output logic [NUM_BUF-1:0] fullQ,
  output logic [SEL_W-1:0]   toggleQ,
  output logic               overrunQ
);
  logic [NUM_BUF-1:0] fullD;
  logic [SEL_W-1:0]   toggleD;

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_flag
    assign fullD[i] = (fullQ[i] & ~strobe.clrFull[i]) | strobe.setFull[i];
    always_ff @(posedge clk) begin
      if (!rstN) fullQ[i] <= 1'b0;
      else       fullQ[i] <= fullD[i];
    end
  end

  always_comb begin
    toggleD = toggleQ;
    unique case (fullD)
      2'b01: toggleD = 1'b1;
      2'b10: toggleD = 1'b0;
      2'b11: toggleD = toggleQ;
      default: begin
        if (strobe.clrFull == 2'b10)  toggleD = 1'b1;
        else if (strobe.clrFull[0])   toggleD = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toggleQ  <= '0;
      overrunQ <= 1'b0;
    end else begin
      toggleQ  <= toggleD;
      overrunQ <= overrunQ | strobe.overrun;
    end
  end

  AST_ONE_FULL_POINTS_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(fullQ) == 1) |-> !fullQ[toggleQ]); // R3
  AST_BOTH_FULL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (fullQ == 2'b11 && strobe.clrFull == '0) |=> $stable(toggleQ) && fullQ == 2'b11); // R4
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overrunQ |=> overrunQ); // R5
  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.setFull != '0) |=> (fullQ & $past(strobe.setFull)) == $past(strobe.setFull)); // R8
endmodule

// File: rtl/pp_flow.sv
module pp_flow (
  input  logic clk,
  input  logic rstN,
  input  logic allFull,
  input  logic srcSel,
  input  logic dmaReq,
  output logic usbHoldOff,
  output logic dmaAck
);
  assign usbHoldOff = allFull & ~srcSel;
  assign dmaAck     = srcSel & dmaReq & ~allFull;

  AST_USB_HOLD_ONLY_FULL: assert property (@(posedge clk) disable iff (!rstN)
    usbHoldOff |-> (allFull && !srcSel)); // R10
  AST_NO_ACK_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    dmaAck |-> (!allFull && dmaReq && srcSel)); // R11
endmodule

// File: rtl/pingpong_toggle_ctrl.sv
module pingpong_toggle_ctrl
  import pp_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic fillDone,
  input  logic swClrA,
  input  logic swClrB,
  input  logic autoXfer,
  input  logic drainDoneA,
  input  logic drainDoneB,
  input  logic srcSel,
  input  logic dmaReq,
  output logic usbHoldOff,
  output logic dmaAck,
  output logic fullA,
  output logic fullB,
  output logic toggle,
  output logic bothFull,
  output logic overrun
);
  ppStrobe_t          strobe;
  logic [NUM_BUF-1:0] fullQ;
  logic [SEL_W-1:0]   toggleQ;

  pp_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .fillDone  (fillDone),
    .swClr     ({swClrB, swClrA}),
    .drainDone ({drainDoneB, drainDoneA}),
    .autoXfer  (autoXfer),
    .fullQ     (fullQ),
    .toggleQ   (toggleQ),
    .strobe    (strobe)
  );

  pp_regs u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .fullQ    (fullQ),
    .toggleQ  (toggleQ),
    .overrunQ (overrun)
  );

  pp_flow u_flow (
    .clk        (clk),
    .rstN       (rstN),
    .allFull    (bothFull),
    .srcSel     (srcSel),
    .dmaReq     (dmaReq),
    .usbHoldOff (usbHoldOff),
    .dmaAck     (dmaAck)
  );

  assign fullA    = fullQ[0];
  assign fullB    = fullQ[1];
  assign toggle   = toggleQ;
  assign bothFull = fullA & fullB;

  AST_BOTH_FULL_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    bothFull == (fullQ == 2'b11)); // R12
endmodule

// File: tb/pingpong_toggle_ctrl_bench.sv
`timescale 1ns/1ps
module pingpong_toggle_ctrl_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fillDone = 0, swClrA = 0, swClrB = 0, autoXfer = 0;
  logic drainDoneA = 0, drainDoneB = 0, srcSel = 0, dmaReq = 0;
  logic usbHoldOff, dmaAck, fullA, fullB, toggle, bothFull, overrun;

  int nChecks = 0;
  int nFails = 0;
  logic mA = 0, mB = 0, mT = 0, mO = 0;

  always #2.5 clk = ~clk;

  pingpong_toggle_ctrl u_pingpong_toggle_ctrl (
    .clk(clk), .rstN(rstN), .fillDone(fillDone), .swClrA(swClrA), .swClrB(swClrB),
    .autoXfer(autoXfer), .drainDoneA(drainDoneA), .drainDoneB(drainDoneB),
    .srcSel(srcSel), .dmaReq(dmaReq), .usbHoldOff(usbHoldOff), .dmaAck(dmaAck),
    .fullA(fullA), .fullB(fullB), .toggle(toggle), .bothFull(bothFull), .overrun(overrun)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic expHold(input logic a, input logic b, input logic s);
    return a & b & ~s;
  endfunction

  function automatic logic expAck(input logic a, input logic b, input logic s, input logic r);
    return s & r & ~(a & b);
  endfunction

  task automatic checkAll();
    check("R2 R6 R7 R8 fullA", fullA, mA);
    check("R2 R6 R7 R8 fullB", fullB, mB);
    check("R3 R4 R9 toggle", toggle, mT);
    check("R5 overrun", overrun, mO);
    check("R12 bothFull", bothFull, mA & mB);
    check("R10 usbHoldOff", usbHoldOff, expHold(mA, mB, srcSel));
    check("R11 dmaAck", dmaAck, expAck(mA, mB, srcSel, dmaReq));
  endtask

  // Reference model of one clock edge, written from the requirements.
  task automatic advance();
    logic both, cA, cB, sA, sB, nA, nB, nT;
    both = mA & mB;
    sA = fillDone & ~both & ~mT;
    sB = fillDone & ~both & mT;
    cA = mA & (autoXfer ? drainDoneA : swClrA);
    cB = mB & (autoXfer ? drainDoneB : swClrB);
    nA = sA | (mA & ~cA);
    nB = sB | (mB & ~cB);
    nT = mT;
    if (nA & ~nB) nT = 1'b1;
    else if (~nA & nB) nT = 1'b0;
    else if (~nA & ~nB) begin
      if (cB & ~cA) nT = 1'b1;
      else if (cA) nT = 1'b0;
    end
    mO = mO | (fillDone & both);
    mA = nA; mB = nB; mT = nT;
  endtask

  task automatic step(input logic fd, input logic ca, input logic cb, input logic ax,
                      input logic da, input logic db, input logic ss, input logic rq);
    @(negedge clk);
    checkAll();
    fillDone = fd; swClrA = ca; swClrB = cb; autoXfer = ax;
    drainDoneA = da; drainDoneB = db; srcSel = ss; dmaReq = rq;
    #1;
    check("R10 usbHoldOff comb", usbHoldOff, expHold(mA, mB, srcSel));
    check("R11 dmaAck comb", dmaAck, expAck(mA, mB, srcSel, dmaReq));
    advance();
  endtask

  initial begin : watchdog
    #(5ns * 150000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 fullA", fullA, 1'b0);
    check("R1 fullB", fullB, 1'b0);
    check("R1 toggle", toggle, 1'b0);
    check("R1 overrun", overrun, 1'b0);
    check("R1 usbHoldOff", usbHoldOff, 1'b0);
    check("R1 dmaAck", dmaAck, 1'b0);
    //   fd ca cb ax da db ss rq
    step(1, 0, 0, 0, 0, 0, 0, 0); // R2 fill A, R3 toggle -> 1
    step(1, 0, 0, 0, 0, 0, 0, 0); // R2 fill B, R4 both full
    step(1, 0, 0, 0, 0, 0, 0, 0); // R4 ignored, R5 overrun, R10 hold-off
    step(0, 0, 0, 0, 0, 0, 1, 1); // R11 ack withheld
    step(0, 0, 0, 0, 1, 1, 0, 0); // R6 drain ignored in normal mode
    step(0, 0, 1, 0, 0, 0, 1, 1); // R6 clear B -> toggle 1
    step(1, 1, 0, 0, 0, 0, 1, 1); // R8 fill B with clear A
    step(0, 1, 1, 1, 0, 0, 0, 0); // R7 sw clears ignored in auto mode
    step(0, 0, 0, 1, 0, 1, 0, 0); // R7 drain clears B, R9 toggle -> 1
    step(0, 0, 0, 1, 0, 0, 0, 0);
    step(1, 0, 0, 1, 0, 0, 0, 0); // fill B
    step(0, 0, 0, 1, 0, 1, 0, 0); // R9 empty after B-only clear
    step(1, 0, 0, 0, 0, 0, 0, 0); // fill B
    step(1, 0, 0, 0, 0, 0, 0, 0); // fill A, both full
    step(0, 1, 1, 0, 0, 0, 0, 0); // R9 both cleared -> toggle 0
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      step(r[0] | r[1], ($urandom % 4) == 0, ($urandom % 4) == 0,
           (i / 500) % 2 == 1, ($urandom % 4) == 0, ($urandom % 4) == 0,
           r[2], r[3]);
    end
    step(0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    checkAll();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule